// File: doc/BRIEF.md
# Two-Line Read Buffer with Next-Line Prefetch

The block sits between bus masters and a memory port. It holds two cache lines of four 32-bit doublewords each, 32 bytes in all. A master presents a doubleword address, the length of its burst in doublewords and a read-ahead enable. It holds the request until a response comes back. A read whose line is present is answered in the same cycle. A read whose line is absent starts a line fill, and the whole four-doubleword line is fetched even when only one doubleword was asked for. The held request is then answered in the cycle after the fill lands.

When read-ahead is enabled and the missing request is a burst of two or more doublewords, the buffer also fetches the following line. This happens only after the demand line has been filled. The following line goes into the slot that does not hold the demand line. Writes elsewhere in the system report their line address, and any buffered copy of that line is dropped, including a copy that is still being filled. The memory side is abstract: the buffer asks for one line at a time, and the memory returns its four doublewords in order, one per beat, with any number of idle cycles between beats.

Top module: `line_read_buffer`

## Requirements
- R1: After reset both lines are invalid, `rd_resp_valid` and `fill_req_valid` are 0, and the first read of any address causes a line fill.
- R2: A read whose line is held returns `rd_resp_valid`=1 in the same cycle as `rd_valid`, with the doubleword selected by address bits [1:0] of that line.
- R3: A read whose line is not held raises exactly one fill request whose `fill_req_line` equals the doubleword address shifted right by 2. No response is given before the fill completes.
- R4: A fill stores all four doublewords of the line, with beat k stored as word k. After a single-doubleword miss, every word of that line hits with zero wait.
- R5: When `ra_en`=1 and `rd_len`>=2 on a miss, a second fill for line+1 (modulo the line address space) follows the demand fill, and words of that line then hit.
- R6: When `ra_en`=0, or `rd_len` is 0 or 1, a miss produces only the demand fill.
- R7: The prefetched line goes into the slot other than the demand slot, so both the demand line and the next line hit afterwards.
- R8: No fill request is raised while the beats of an accepted fill are still outstanding. The demand fill finishes before the prefetch request appears.
- R9: A write pulse whose `wr_line` matches a held line invalidates that line only; the other line still hits.
- R10: A write to the line being filled, seen at any point during that fill, leaves the line invalid when the fill completes. A waiting read then refetches it.
- R11: On a miss the victim slot is slot 0 if it is invalid, otherwise slot 1 if it is invalid, otherwise the slot not used by the most recent hit.
- R12: A fill request that is not yet accepted stays asserted with an unchanged line address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read request, held until answered |
| rd_addr | input | 30 | Doubleword address of the read |
| rd_len | input | 5 | Burst length of the request in doublewords |
| ra_en | input | 1 | Read-ahead enable |
| rd_resp_valid | output | 1 | Read answered this cycle |
| rd_resp_data | output | 32 | Read data |
| wr_valid | input | 1 | A write to memory happened this cycle |
| wr_line | input | 28 | Line address of that write |
| fill_req_valid | output | 1 | Line fill request to memory |
| fill_req_line | output | 28 | Line address to fetch |
| fill_req_ready | input | 1 | Memory accepts the fill request |
| fill_beat_valid | input | 1 | One doubleword of the fill arrives |
| fill_beat_data | input | 32 | Fill data, words in ascending order |

## Verification
Single-doubleword misses are compared with burst misses, with read-ahead on and off. This separates a plain full-line fill from a fill followed by a next-line prefetch, and it shows whether the burst-length gate works. Reads of the other words of a freshly filled line, and of the prefetched line, show whether the whole line was stored and which slot the prefetch used. Writes aimed at held lines and at a line in flight, a prefetch from the last line address, and a random mix over six neighbouring lines exercise invalidation, wrap-around and the replacement choice against a bench model of the slot contents.

// File: rtl/rb_pkg.sv
package rb_pkg;

  localparam int SLOTS = 2;

  typedef enum logic [2:0] {
    FS_IDLE     = 3'd0,
    FS_DEM_REQ  = 3'd1,
    FS_DEM_DATA = 3'd2,
    FS_PF_REQ   = 3'd3,
    FS_PF_DATA  = 3'd4
  } fill_state_e;

endpackage

// File: rtl/rb_tag_array.sv
module rb_tag_array
  import rb_pkg::*;
#(
  parameter int TAG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic             hit_slot,
  input  logic             touch_en,
  input  logic             clr_en,
  input  logic             clr_slot,
  input  logic             set_en,
  input  logic             set_slot,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             inv_en,
  input  logic [TAG_W-1:0] inv_tag,
  output logic             victim
);

  logic [SLOTS-1:0] match;
  logic [SLOTS-1:0] slot_valid;
  logic             mru_q;
  logic             mru_d;

  for (genvar s = 0; s < SLOTS; s++) begin : gen_slot
    logic             valid_q;
    logic             valid_d;
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] tag_d;

    always_comb begin
      valid_d = valid_q;
      tag_d   = tag_q;
      if (inv_en && valid_q && (tag_q == inv_tag)) begin
        valid_d = 1'b0;
      end
      if (clr_en && (clr_slot == 1'(s))) begin
        valid_d = 1'b0;
      end
      if (set_en && (set_slot == 1'(s))) begin
        valid_d = 1'b1;
        tag_d   = set_tag;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        tag_q   <= '0;
      end else begin
        valid_q <= valid_d;
        tag_q   <= tag_d;
      end
    end

    assign slot_valid[s] = valid_q;
    assign match[s]      = valid_q && (tag_q == lk_tag);
  end

  assign hit      = |match;
  assign hit_slot = match[1];

  always_comb begin
    mru_d = mru_q;
    if (touch_en) begin
      mru_d = hit_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mru_q <= 1'b0;
    end else begin
      mru_q <= mru_d;
    end
  end

  always_comb begin
    if (!slot_valid[0]) begin
      victim = 1'b0;
    end else if (!slot_valid[1]) begin
      victim = 1'b1;
    end else begin
      victim = ~mru_q;
    end
  end

endmodule

// File: rtl/rb_line_store.sv
module rb_line_store
  import rb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wr_slot,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_slot,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);

  localparam int ENTRIES = SLOTS * WORDS;

  logic [ENTRIES*DATA_W-1:0] flat;

  for (genvar s = 0; s < SLOTS; s++) begin : gen_line
    for (genvar w = 0; w < WORDS; w++) begin : gen_word
      logic [DATA_W-1:0] word_q;
      logic              word_en;

      assign word_en = we && (wr_slot == 1'(s)) && (wr_word == WORD_W'(w));

      always_ff @(posedge clk) begin
        if (word_en) begin
          word_q <= wr_data;
        end
      end

      assign flat[(s*WORDS+w)*DATA_W +: DATA_W] = word_q;
    end
  end

  logic [WORD_W:0] rd_idx;
  assign rd_idx  = {rd_slot, rd_word};
  assign rd_data = flat[rd_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/rb_fill_ctrl.sv
module rb_fill_ctrl
  import rb_pkg::*;
#(
  parameter int TAG_W = 28,
  parameter int WORDS = 4,
  parameter int LEN_W = 5,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic              ra_en,
  input  logic              hit,
  input  logic              victim,
  input  logic              inv_en,
  input  logic [TAG_W-1:0]  inv_tag,
  input  logic              mem_ready,
  input  logic              mem_beat,
  output logic              mem_req_valid,
  output logic [TAG_W-1:0]  mem_req_line,
  output logic              st_we,
  output logic              st_slot,
  output logic [WORD_W-1:0] st_word,
  output logic              set_en,
  output logic              set_slot,
  output logic [TAG_W-1:0]  set_tag,
  output logic              clr_en,
  output logic              clr_slot
);

  fill_state_e       state_q, state_d;
  logic [TAG_W-1:0]  line_q, line_d;
  logic              slot_q, slot_d;
  logic              pf_q, pf_d;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic              poison_q, poison_d;
  logic              poison_now;
  logic              last_beat;
  logic              in_data;

  assign in_data    = (state_q == FS_DEM_DATA) || (state_q == FS_PF_DATA);
  assign poison_now = inv_en && (inv_tag == line_q) && (state_q != FS_IDLE);
  assign last_beat  = (beat_q == WORD_W'(WORDS - 1));

  assign mem_req_line = line_q;
  assign st_slot      = slot_q;
  assign st_word      = beat_q;
  assign set_slot     = slot_q;
  assign set_tag      = line_q;

  always_comb begin
    state_d       = state_q;
    line_d        = line_q;
    slot_d        = slot_q;
    pf_d          = pf_q;
    beat_d        = beat_q;
    poison_d      = poison_q | poison_now;
    mem_req_valid = 1'b0;
    st_we         = 1'b0;
    set_en        = 1'b0;
    clr_en        = 1'b0;
    clr_slot      = victim;

    case (state_q)
      FS_IDLE: begin
        poison_d = 1'b0;
        if (rd_valid && !hit) begin
          line_d   = rd_tag;
          slot_d   = victim;
          pf_d     = ra_en && (rd_len >= LEN_W'(2));
          clr_en   = 1'b1;
          clr_slot = victim;
          state_d  = FS_DEM_REQ;
        end
      end
      FS_DEM_REQ, FS_PF_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_ready) begin
          beat_d  = '0;
          state_d = (state_q == FS_DEM_REQ) ? FS_DEM_DATA : FS_PF_DATA;
        end
      end
      FS_DEM_DATA, FS_PF_DATA: begin
        if (mem_beat) begin
          st_we  = 1'b1;
          beat_d = beat_q + WORD_W'(1);
          if (last_beat) begin
            set_en = !(poison_q || poison_now);
            if ((state_q == FS_DEM_DATA) && pf_q) begin
              line_d   = line_q + TAG_W'(1);
              slot_d   = ~slot_q;
              clr_en   = 1'b1;
              clr_slot = ~slot_q;
              poison_d = 1'b0;
              state_d  = FS_PF_REQ;
            end else begin
              state_d = FS_IDLE;
            end
          end
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      line_q   <= '0;
      slot_q   <= 1'b0;
      pf_q     <= 1'b0;
      beat_q   <= '0;
      poison_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      line_q   <= line_d;
      slot_q   <= slot_d;
      pf_q     <= pf_d;
      beat_q   <= beat_d;
      poison_q <= poison_d;
    end
  end

  logic unused_in_data;
  assign unused_in_data = in_data;

endmodule

// File: rtl/line_read_buffer.sv
module line_read_buffer
  import rb_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LEN_W  = 5,
  localparam int WORD_W = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic              ra_en,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_resp_data,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_line,
  output logic              fill_req_valid,
  output logic [TAG_W-1:0]  fill_req_line,
  input  logic              fill_req_ready,
  input  logic              fill_beat_valid,
  input  logic [DATA_W-1:0] fill_beat_data
);

  logic [TAG_W-1:0]  rd_tag;
  logic [WORD_W-1:0] rd_word;
  logic              hit;
  logic              hit_slot;
  logic              victim;
  logic              st_we;
  logic              st_slot;
  logic [WORD_W-1:0] st_word;
  logic              set_en;
  logic              set_slot;
  logic [TAG_W-1:0]  set_tag;
  logic              clr_en;
  logic              clr_slot;

  assign rd_tag        = rd_addr[ADDR_W-1:WORD_W];
  assign rd_word       = rd_addr[WORD_W-1:0];
  assign rd_resp_valid = rd_valid && hit;

  rb_tag_array #(.TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_tag   (rd_tag),
    .hit      (hit),
    .hit_slot (hit_slot),
    .touch_en (rd_resp_valid),
    .clr_en   (clr_en),
    .clr_slot (clr_slot),
    .set_en   (set_en),
    .set_slot (set_slot),
    .set_tag  (set_tag),
    .inv_en   (wr_valid),
    .inv_tag  (wr_line),
    .victim   (victim)
  );

  rb_line_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
    .clk     (clk),
    .we      (st_we),
    .wr_slot (st_slot),
    .wr_word (st_word),
    .wr_data (fill_beat_data),
    .rd_slot (hit_slot),
    .rd_word (rd_word),
    .rd_data (rd_resp_data)
  );

  rb_fill_ctrl #(.TAG_W(TAG_W), .WORDS(WORDS), .LEN_W(LEN_W)) u_fill (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid      (rd_valid),
    .rd_tag        (rd_tag),
    .rd_len        (rd_len),
    .ra_en         (ra_en),
    .hit           (hit),
    .victim        (victim),
    .inv_en        (wr_valid),
    .inv_tag       (wr_line),
    .mem_ready     (fill_req_ready),
    .mem_beat      (fill_beat_valid),
    .mem_req_valid (fill_req_valid),
    .mem_req_line  (fill_req_line),
    .st_we         (st_we),
    .st_slot       (st_slot),
    .st_word       (st_word),
    .set_en        (set_en),
    .set_slot      (set_slot),
    .set_tag       (set_tag),
    .clr_en        (clr_en),
    .clr_slot      (clr_slot)
  );

endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int TAG_W = 28,
  parameter int WORDS = 4,
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             rd_resp_valid,
  input logic             fill_req_valid,
  input logic [TAG_W-1:0] fill_req_line,
  input logic             fill_req_ready,
  input logic             fill_beat_valid
);

  logic [CNT_W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (fill_req_valid && fill_req_ready) begin
      pend_q <= CNT_W'(WORDS);
    end else if (fill_beat_valid && (pend_q != '0)) begin
      pend_q <= pend_q - CNT_W'(1);
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!fill_req_valid && !rd_resp_valid));

  p_resp_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |-> rd_valid);

  p_no_req_during_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |-> !fill_req_valid);

  p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_line)));

endmodule

bind line_read_buffer rb_checker #(.TAG_W(TAG_W), .WORDS(WORDS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .rd_valid        (rd_valid),
  .rd_resp_valid   (rd_resp_valid),
  .fill_req_valid  (fill_req_valid),
  .fill_req_line   (fill_req_line),
  .fill_req_ready  (fill_req_ready),
  .fill_beat_valid (fill_beat_valid)
);

// File: tb/line_read_buffer_tb.sv
`timescale 1ns/1ps
module line_read_buffer_tb;

  logic        clk;
  logic        rst_n;
  logic        rd_valid;
  logic [29:0] rd_addr;
  logic [4:0]  rd_len;
  logic        ra_en;
  logic        rd_resp_valid;
  logic [31:0] rd_resp_data;
  logic        wr_valid;
  logic [27:0] wr_line;
  logic        fill_req_valid;
  logic [27:0] fill_req_line;
  logic        fill_req_ready;
  logic        fill_beat_valid;
  logic [31:0] fill_beat_data;

  int checks = 0;
  int errors = 0;
  int fill_cnt = 0;
  logic [27:0] fill_log [1024];

  logic        mv [2];
  logic [27:0] mt [2];
  logic        mmru;

  line_read_buffer u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] memfn(logic [27:0] line, logic [1:0] w);
    return {line, w, 2'b01} ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder: random acceptance delay, four in-order beats
  initial begin
    fill_req_ready  = 1'b0;
    fill_beat_valid = 1'b0;
    fill_beat_data  = '0;
    forever begin
      @(negedge clk);
      fill_req_ready  = 1'b0;
      fill_beat_valid = 1'b0;
      if (rst_n && fill_req_valid) begin
        logic [27:0] ln;
        repeat ($urandom % 3) @(negedge clk);
        ln = fill_req_line;
        fill_req_ready = 1'b1;
        if (fill_cnt < 1024) fill_log[fill_cnt] = ln;
        fill_cnt++;
        @(negedge clk);
        fill_req_ready = 1'b0;
        for (int w = 0; w < 4; w++) begin
          repeat ($urandom % 2) @(negedge clk);
          fill_beat_valid = 1'b1;
          fill_beat_data  = memfn(ln, 2'(w));
          @(negedge clk);
          fill_beat_valid = 1'b0;
        end
      end
    end
  end

  function automatic int model_slot(logic [27:0] line);
    for (int s = 0; s < 2; s++) if (mv[s] && mt[s] == line) return s;
    return -1;
  endfunction

  // read with checks; refetch = extra demand fills expected (write during fill)
  task automatic do_read(logic [29:0] a, logic [4:0] len, logic ra, string req, int refetch);
    logic [27:0] line;
    int s, start, waits, expn;
    bit got, pf;
    logic vic;
    line  = a[29:2];
    s     = model_slot(line);
    start = fill_cnt;
    pf    = (s < 0) && ra && (len >= 2);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_len = len; ra_en = ra;
    waits = 0; got = 0;
    while (!got && waits < 400) begin
      #1;
      if (rd_resp_valid) got = 1;
      else begin @(negedge clk); waits++; end
    end
    chk(got, {req, " response arrives"}, 64'(got), 64'd1);
    if (got) chk(rd_resp_data == memfn(line, a[1:0]), {req, " data"}, 64'(rd_resp_data), 64'(memfn(line, a[1:0])));
    if (s >= 0) chk(waits == 0, {req, " R2 zero-wait hit"}, 64'(waits), 64'd0);
    else        chk(waits > 0, {req, " R3 miss waits for fill"}, 64'(waits), 64'd1);
    @(negedge clk);
    rd_valid = 1'b0;
    repeat (40) @(negedge clk);
    expn = (s >= 0) ? 0 : (1 + refetch + (pf ? 1 : 0));
    chk(fill_cnt - start == expn, {req, pf ? " R5" : " R6", " fill count"}, 64'(fill_cnt - start), 64'(expn));
    if (expn >= 1 && fill_cnt - start == expn) begin
      chk(fill_log[start] == line, {req, " R3 demand line"}, 64'(fill_log[start]), 64'(line));
      if (refetch > 0)
        chk(fill_log[start+1] == line, {req, " R10 refetch line"}, 64'(fill_log[start+1]), 64'(line));
      if (pf)
        chk(fill_log[start+expn-1] == line + 28'd1, {req, " R5 prefetch line"},
            64'(fill_log[start+expn-1]), 64'(line + 28'd1));
    end
    if (s >= 0) mmru = s[0];
    else begin
      vic = !mv[0] ? 1'b0 : (!mv[1] ? 1'b1 : ~mmru);
      mv[vic] = 1'b1; mt[vic] = line; mmru = vic;
      if (pf) begin mv[~vic] = 1'b1; mt[~vic] = line + 28'd1; end
    end
  endtask

  task automatic do_write(logic [27:0] line);
    @(negedge clk);
    wr_valid = 1'b1; wr_line = line;
    @(negedge clk);
    wr_valid = 1'b0;
    for (int s = 0; s < 2; s++) if (mv[s] && mt[s] == line) mv[s] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [27:0] base;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rd_valid = 1'b0; rd_addr = '0; rd_len = '0; ra_en = 1'b0;
    wr_valid = 1'b0; wr_line = '0;
    mv[0] = 0; mv[1] = 0; mt[0] = '0; mt[1] = '0; mmru = 0;
    repeat (3) @(negedge clk);
    chk(!rd_resp_valid && !fill_req_valid, "R1 reset outputs quiet", {fill_req_valid, rd_resp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fill_req_valid, "R1 idle after reset", 64'(fill_req_valid), 0);

    // R1/R4/R6: single-word miss fills whole line, no prefetch even with read-ahead
    do_read({28'h0001230, 2'd2}, 5'd1, 1'b1, "R1 R4 R6", 0);
    for (int w = 0; w < 4; w++) do_read({28'h0001230, 2'(w)}, 5'd1, 1'b0, "R4 other words", 0);

    // R5/R7: burst miss with read-ahead fetches next line into the other slot
    do_read({28'h0004560, 2'd0}, 5'd4, 1'b1, "R5 R7 R8", 0);
    do_read({28'h0004561, 2'd3}, 5'd1, 1'b0, "R5 prefetched word", 0);
    do_read({28'h0004560, 2'd1}, 5'd1, 1'b0, "R7 demand line kept", 0);

    // R6: burst without read-ahead, and length-two boundary with read-ahead
    do_read({28'h0007000, 2'd0}, 5'd8, 1'b0, "R6 ra off", 0);
    do_read({28'h0008000, 2'd1}, 5'd2, 1'b1, "R5 len two", 0);

    // R9: invalidate one held line, the other stays
    do_write(28'h0008000);
    do_read({28'h0008001, 2'd0}, 5'd1, 1'b0, "R9 other line hits", 0);
    do_read({28'h0008000, 2'd2}, 5'd1, 1'b0, "R9 invalidated refetch", 0);

    // R11: both valid, touch one, new miss replaces the untouched one
    do_read({28'h0008001, 2'd1}, 5'd1, 1'b0, "R11 touch", 0);
    do_read({28'h0009999, 2'd0}, 5'd1, 1'b0, "R11 miss", 0);
    do_read({28'h0008001, 2'd2}, 5'd1, 1'b0, "R11 survivor hits", 0);

    // R10: write to the line in flight forces a refetch
    fork
      do_read({28'h000ABCD, 2'd3}, 5'd1, 1'b0, "R10", 1);
      begin
        int c0;
        c0 = fill_cnt;
        wait (fill_cnt == c0 + 1);
        @(negedge clk);
        wr_valid = 1'b1; wr_line = 28'h000ABCD;
        @(negedge clk);
        wr_valid = 1'b0;
      end
    join

    // R5 wrap: prefetch after the last line address
    do_read({28'hFFFFFFF, 2'd0}, 5'd4, 1'b1, "R5 wrap", 0);
    do_read({28'h0000000, 2'd2}, 5'd1, 1'b0, "R5 wrapped line hits", 0);

    // random mix
    base = 28'h0ABCDE0;
    for (int i = 0; i < 300; i++) begin
      logic [27:0] ln;
      ln = base + 28'($urandom % 6);
      if ($urandom % 5 == 0) do_write(ln);
      else do_read({ln, 2'($urandom % 4)}, 5'(1 + $urandom % 4), 1'($urandom % 2), "R2 R3 R11 random", 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule